// File: doc/BRIEF.md
# Fuse Array Word Reader

This block lets a host fetch 16-bit words from a small one-time-programmable fuse array through a plain register port. Software first raises the external module-enable line and waits until the status register shows the controller idle and ready. It writes a block number (0 to 31) into the index register and sets the start bit of the command register. It then polls status until the done flag appears, reads the captured word from the data register, and writes the clear bit. After the access it drops module enable again.

A byte address A of the 64-byte fuse space lives in block A/2. Software picks the byte by shifting the word right by 8 × (A mod 2). The array access itself takes a fixed, parameterised number of cycles. For that long the block holds a request and the selected block number towards the array. It then samples the array's data lines into the data register.

Top module: `otp_read_ctrl`

## Requirements
- R1: After reset, with module enable high and protect low, status (offset 0x14) reads 0x04 (only the ready bit, bit 2, set), and the data register (0x04) and the index register (0x0C) read 0.
- R2: The index register (0x0C) keeps only the low 5 bits of a write; bits above 4 read back as 0.
- R3: Writing 1 to command bit 1 (offset 0x10) while ready and not done sets read-busy (status bit 1) and clears ready (bit 2). Busy and ready are never set together. The request output stays high with the latched block number for exactly LATENCY cycles.
- R4: When the access ends, the data register holds the array word of the latched block. Status then shows done (bit 4) and ready, with busy low.
- R5: Done stays set until 1 is written to command bit 2 or module enable falls. The clear leaves the data register unchanged.
- R6: A start written while busy, or while done is still set, is ignored: no new access begins and the data register keeps its value. An index written during an access does not change the block being read.
- R7: While module enable is low, register writes have no effect and status reads 0.
- R8: Dropping module enable during an access aborts it. After enable returns, status reads ready only (no done, no busy) and the data register keeps its prior value.
- R9: The command register reads 0. The plain storage registers at 0x00, 0x08, 0x20, 0x24 and 0x28 read back the full word last written. Unmapped offsets such as 0x18 read 0.
- R10: While enabled, status bit 3 follows the protect input and status bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | External module enable |
| protect_in | input | 1 | Static protection flag mirrored in status |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data (combinational) |
| arr_req | output | 1 | Fuse array access in progress |
| arr_index | output | log2(NUM_BLOCKS) | Block number presented to the array |
| arr_data | input | WORD_W | Word returned by the fuse array |

## Verification
The bench builds the block with LATENCY set to 5 and the other parameters at their defaults (32 blocks of 16 bits, a 32-bit register bus, an 8-bit offset). The longer latency leaves room to issue a second start and an index rewrite while a read is still busy. It also lets module enable drop in the middle of an access. The 32 blocks let random byte addresses cover the whole 64-byte space, both byte halves of each word, and the extremes of the index field.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

    // register offsets (software-visible layout)
    localparam logic [7:0] OFS_GCTRL  = 8'h00;
    localparam logic [7:0] OFS_RDATA  = 8'h04;
    localparam logic [7:0] OFS_WDATA  = 8'h08;
    localparam logic [7:0] OFS_INDEX  = 8'h0C;
    localparam logic [7:0] OFS_MODE   = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_WTIME  = 8'h20;
    localparam logic [7:0] OFS_RTIME  = 8'h24;
    localparam logic [7:0] OFS_DEBNC  = 8'h28;

    // plain storage registers
    localparam int NSTORE = 5;
    localparam logic [7:0] STORE_OFS [NSTORE] =
        '{OFS_GCTRL, OFS_WDATA, OFS_WTIME, OFS_RTIME, OFS_DEBNC};

    // command bits
    localparam int CMD_PGM = 0;
    localparam int CMD_RD  = 1;
    localparam int CMD_CLR = 2;

    // status bits
    localparam int ST_PGM   = 0;
    localparam int ST_RBUSY = 1;
    localparam int ST_STBY  = 2;
    localparam int ST_PROT  = 3;
    localparam int ST_DONE  = 4;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_READ
    } seq_state_e;

    typedef struct packed {
        logic prot;
        logic done;
        logic stby;
        logic rbusy;
    } seq_status_t;

    typedef struct packed {
        logic start;
        logic clear;
    } mode_cmd_t;

    function automatic logic [7:0] pack_status(seq_status_t s);
        logic [7:0] v;
        v = '0;
        v[ST_RBUSY] = s.rbusy;
        v[ST_STBY]  = s.stby;
        v[ST_PROT]  = s.prot;
        v[ST_DONE]  = s.done;
        return v;
    endfunction

endpackage

// File: rtl/otp_rd_regs.sv
module otp_rd_regs
    import otp_rd_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 5,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [WORD_W-1:0] word_q,
    input  logic [7:0]        stat_bits,
    output logic [BLK_W-1:0]  blk_index,
    output mode_cmd_t         cmd
);

    logic wr_ok;
    assign wr_ok = wr && en;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic [BUS_W-1:0] store_q [NSTORE];

    for (genvar g = 0; g < NSTORE; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (wr_ok && hit(addr, STORE_OFS[g])) begin
                store_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_index <= '0;
        end else if (wr_ok && hit(addr, OFS_INDEX)) begin
            blk_index <= wdata[BLK_W-1:0];
        end
    end

    always_comb begin
        cmd.start = wr_ok && hit(addr, OFS_MODE) && wdata[CMD_RD];
        cmd.clear = wr_ok && hit(addr, OFS_MODE) && wdata[CMD_CLR];
    end

    always_comb begin
        rdata = '0;
        if (hit(addr, OFS_RDATA)) begin
            rdata = BUS_W'(word_q);
        end else if (hit(addr, OFS_INDEX)) begin
            rdata = BUS_W'(blk_index);
        end else if (hit(addr, OFS_STATUS)) begin
            rdata = BUS_W'(stat_bits);
        end
        for (int k = 0; k < NSTORE; k++) begin
            if (hit(addr, STORE_OFS[k])) begin
                rdata = store_q[k];
            end
        end
    end

endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq
    import otp_rd_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int BLK_W   = 5,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              prot_in,
    input  mode_cmd_t         cmd,
    input  logic [BLK_W-1:0]  blk_index,
    output logic              arr_req,
    output logic [BLK_W-1:0]  arr_index,
    input  logic [WORD_W-1:0] arr_data,
    output logic [WORD_W-1:0] word_q,
    output seq_status_t       stat
);

    localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [BLK_W-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            blk_q   <= '0;
            word_q  <= '0;
        end else if (!en) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            if (cmd.clear) begin
                done_q <= 1'b0;
            end
            case (state_q)
                SEQ_IDLE: begin
                    if (cmd.start && !done_q) begin
                        state_q <= SEQ_READ;
                        cnt_q   <= '0;
                        blk_q   <= blk_index;
                    end
                end
                SEQ_READ: begin
                    if (cnt_q == CNT_LAST) begin
                        word_q  <= arr_data;
                        done_q  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign arr_req   = (state_q == SEQ_READ);
    assign arr_index = blk_q;

    always_comb begin
        stat.rbusy = en && (state_q == SEQ_READ);
        stat.stby  = en && (state_q == SEQ_IDLE);
        stat.done  = en && done_q;
        stat.prot  = en && prot_in;
    end

endmodule

// File: rtl/otp_read_ctrl.sv
module otp_read_ctrl
    import otp_rd_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    parameter int WORD_W     = 16,
    parameter int LATENCY    = 4,
    parameter int BUS_W      = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mod_en,
    input  logic                          protect_in,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [BUS_W-1:0]              reg_wdata,
    output logic [BUS_W-1:0]              reg_rdata,
    output logic                          arr_req,
    output logic [$clog2(NUM_BLOCKS)-1:0] arr_index,
    input  logic [WORD_W-1:0]             arr_data
);

    localparam int BLK_W = $clog2(NUM_BLOCKS);

    mode_cmd_t         cmd;
    logic [BLK_W-1:0]  blk_index;
    logic [WORD_W-1:0] word_q;
    seq_status_t       seq_stat;
    logic [7:0]        stat_bits;

    assign stat_bits = pack_status(seq_stat);

    otp_rd_regs #(
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W),
        .BLK_W (BLK_W),
        .WORD_W(WORD_W)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .en       (mod_en),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .word_q   (word_q),
        .stat_bits(stat_bits),
        .blk_index(blk_index),
        .cmd      (cmd)
    );

    otp_rd_seq #(
        .LATENCY(LATENCY),
        .BLK_W  (BLK_W),
        .WORD_W (WORD_W)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (mod_en),
        .prot_in  (protect_in),
        .cmd      (cmd),
        .blk_index(blk_index),
        .arr_req  (arr_req),
        .arr_index(arr_index),
        .arr_data (arr_data),
        .word_q   (word_q),
        .stat     (seq_stat)
    );

endmodule

// File: rtl/otp_read_ctrl_chk.sv
module otp_read_ctrl_chk
    import otp_rd_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int WORD_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mod_en,
    input logic              protect_in,
    input logic              arr_req,
    input logic [7:0]        stat_bits,
    input logic [WORD_W-1:0] word_q,
    input logic              clr_cmd
);

    localparam int RUN_W = $clog2(LATENCY + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (arr_req) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_busy_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(stat_bits[ST_RBUSY] && stat_bits[ST_STBY]));

    assert_req_len_R3: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> (run_q < RUN_W'(LATENCY)));

    assert_end_done_R4: assert property (@(posedge clk) disable iff (rst)
        (mod_en && $past(mod_en) && $fell(arr_req)) |-> stat_bits[ST_DONE]);

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_bits[ST_DONE] && mod_en && !clr_cmd) |=> (!mod_en || stat_bits[ST_DONE]));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !arr_req |=> $stable(word_q));

    assert_off_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !mod_en |-> (stat_bits == 8'h00));

    assert_prot_mirror_R10: assert property (@(posedge clk) disable iff (rst)
        mod_en |-> (stat_bits[ST_PROT] == protect_in && !stat_bits[ST_PGM]));

endmodule

bind otp_read_ctrl otp_read_ctrl_chk #(
    .LATENCY(LATENCY),
    .WORD_W (WORD_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_en    (mod_en),
    .protect_in(protect_in),
    .arr_req   (arr_req),
    .stat_bits (stat_bits),
    .word_q    (word_q),
    .clr_cmd   (cmd.clear)
);

// File: tb/test_otp_read_ctrl.sv
module test_otp_read_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;
    localparam int NBLK       = 32;
    localparam int WW         = 16;
    localparam int BW         = 32;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mod_en = 1'b1;
    logic          protect_in = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [BW-1:0] reg_wdata = '0;
    logic [BW-1:0] reg_rdata;
    logic          arr_req;
    logic [4:0]    arr_index;
    logic [WW-1:0] arr_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] fuse_word(logic [4:0] b);
        return 16'((32'(b) * 32'h0000_3B1D) ^ 32'h0000_C35A);
    endfunction

    function automatic logic [31:0] exp_status(bit busy, bit stby, bit prot, bit done);
        return {27'b0, done, prot, stby, busy, 1'b0};
    endfunction

    assign arr_data = arr_req ? fuse_word(arr_index) : 16'h0000;

    otp_read_ctrl #(
        .NUM_BLOCKS(NBLK),
        .WORD_W    (WW),
        .LATENCY   (LAT),
        .BUS_W     (BW),
        .ADDR_W    (AW)
    ) i_otp_read_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mod_en    (mod_en),
        .protect_in(protect_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .arr_req   (arr_req),
        .arr_index (arr_index),
        .arr_data  (arr_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // full software read sequence; returns word and number of busy samples
    task automatic do_read(logic [4:0] b, output logic [31:0] w, output int busy_n);
        logic [31:0] s;
        busy_n = 0;
        wr(8'h0C, 32'(b));
        wr(8'h10, 32'h2);
        for (int i = 0; i < 40; i++) begin
            rd(8'h14, s);
            if (s[4]) break;
            if (s[1]) busy_n++;
            @(negedge clk);
        end
        rd(8'h04, w);
        wr(8'h10, 32'h4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        logic [31:0] keep;
        int          bn;
        int          seed;
        seed = $urandom(32'h0000_5A17);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h14, v); check("R1 status after reset", v, exp_status(0, 1, 0, 0));
        rd(8'h04, v); check("R1 data after reset", v, 0);
        rd(8'h0C, v); check("R1 index after reset", v, 0);

        // R10 protect mirror
        protect_in = 1'b1;
        rd(8'h14, v); check("R10 protect high", v, exp_status(0, 1, 1, 0));
        protect_in = 1'b0;
        rd(8'h14, v); check("R10 protect low", v, exp_status(0, 1, 0, 0));

        // R2 index width
        wr(8'h0C, 32'hFFFF_FFE7);
        rd(8'h0C, v); check("R2 index masked", v, 32'h7);

        // R9 storage, command, unmapped
        wr(8'h00, 32'hA1B2_C3D4); wr(8'h08, 32'h0102_0304);
        wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h5555_AAAA); wr(8'h28, 32'h8000_0001);
        rd(8'h00, v); check("R9 store 0x00", v, 32'hA1B2_C3D4);
        rd(8'h08, v); check("R9 store 0x08", v, 32'h0102_0304);
        rd(8'h20, v); check("R9 store 0x20", v, 32'hDEAD_BEEF);
        rd(8'h24, v); check("R9 store 0x24", v, 32'h5555_AAAA);
        rd(8'h28, v); check("R9 store 0x28", v, 32'h8000_0001);
        rd(8'h10, v); check("R9 command reads zero", v, 0);
        rd(8'h18, v); check("R9 unmapped reads zero", v, 0);

        // R3/R4 directed read, index 0 and 31
        do_read(5'd0, w, bn);
        check("R3 busy length blk0", 32'(bn), 32'(LAT));
        check("R4 word blk0", w, 32'(fuse_word(5'd0)));
        do_read(5'd31, w, bn);
        check("R3 busy length blk31", 32'(bn), 32'(LAT));
        check("R4 word blk31", w, 32'(fuse_word(5'd31)));

        // R3/R6 start during busy, index rewrite during busy
        wr(8'h0C, 32'd3);
        wr(8'h10, 32'h2);
        rd(8'h14, v); check("R3 busy not ready", v, exp_status(1, 0, 0, 0));
        check("R3 request high", 32'(arr_req), 1);
        check("R3 request index", 32'(arr_index), 3);
        wr(8'h0C, 32'd9);
        wr(8'h10, 32'h2);
        repeat (LAT + 2) @(negedge clk);
        rd(8'h14, v); check("R4 done and ready", v, exp_status(0, 1, 0, 1));
        rd(8'h04, w); check("R6 latched block read", w, 32'(fuse_word(5'd3)));

        // R5 sticky done
        repeat (6) @(negedge clk);
        rd(8'h14, v); check("R5 done still set", v, exp_status(0, 1, 0, 1));

        // R6 start while done
        wr(8'h10, 32'h2);
        rd(8'h14, v); check("R6 start ignored while done", v, exp_status(0, 1, 0, 1));
        check("R6 no request while done", 32'(arr_req), 0);
        repeat (LAT + 1) @(negedge clk);
        rd(8'h04, v); check("R6 data kept", v, 32'(fuse_word(5'd3)));

        // R5 clear keeps data
        wr(8'h10, 32'h4);
        rd(8'h14, v); check("R5 clear drops done", v, exp_status(0, 1, 0, 0));
        rd(8'h04, v); check("R5 clear keeps data", v, 32'(fuse_word(5'd3)));

        // R7 disabled
        wr(8'h0C, 32'd12);
        @(negedge clk);
        mod_en = 1'b0;
        protect_in = 1'b1;
        rd(8'h14, v); check("R7 status zero when off", v, 0);
        wr(8'h0C, 32'd20);
        wr(8'h20, 32'h0000_0000);
        wr(8'h10, 32'h2);
        check("R7 no request when off", 32'(arr_req), 0);
        mod_en = 1'b1;
        protect_in = 1'b0;
        rd(8'h0C, v); check("R7 index unchanged", v, 12);
        rd(8'h20, v); check("R7 storage unchanged", v, 32'hDEAD_BEEF);

        // R8 abort mid-read
        rd(8'h04, keep);
        wr(8'h0C, 32'd7);
        wr(8'h10, 32'h2);
        @(negedge clk);
        mod_en = 1'b0;
        repeat (LAT + 3) @(negedge clk);
        mod_en = 1'b1;
        @(negedge clk);
        rd(8'h14, v); check("R8 ready after abort", v, exp_status(0, 1, 0, 0));
        rd(8'h04, v); check("R8 data unchanged after abort", v, keep);
        check("R8 no request after abort", 32'(arr_req), 0);
        do_read(5'd7, w, bn);
        check("R8 read after abort", w, 32'(fuse_word(5'd7)));

        // random byte reads across the 64-byte space (R4, R3)
        for (int n = 0; n < 40; n++) begin
            int   a;
            logic [7:0] exp_b;
            a = int'($urandom_range(63, 0));
            do_read(5'(a / 2), w, bn);
            exp_b = 8'(fuse_word(5'(a / 2)) >> ((a % 2) * 8));
            check("R4 random byte", 32'(8'(w >> ((a % 2) * 8))), 32'(exp_b));
            check("R3 random busy length", 32'(bn), 32'(LAT));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule